// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block sends a single byte, either an address byte or a data byte, as the master on an I2C bus, then reads back the acknowledge that the slave returns on the ninth clock. It assumes that a start condition has already been issued, so SCL sits held low when the block is idle. A host loads the byte through a write strobe. The block then paces SCL with a reloadable baud counter, shifts the byte out most significant bit first, and frees SDA for the acknowledge bit.

Both bus lines are modelled as open-drain. A line enable of 1 pulls the line low and a 0 releases it. The SDA level is read back through a synchronizer so that the acknowledge can be sampled. Four flags report progress to the host: a buffer-full flag, a sticky write-collision flag, the acknowledge status and a sticky completion flag. After the ninth clock the block stops, with SCL held low and SDA released. It stays there until the host loads the next byte.

Top module: `i2c_byte_tx`

## Requirements
- R1: A write (`wr_en`=1) while the engine is idle loads the byte. `buf_full` reads 1 on the following cycle, and the first bit period begins with SCL low.
- R2: `sda_oe` changes only while SCL is held low, and at the earliest one cycle after SCL was pulled low. Each low period after the first lasts T = max(reload,1)+1 clock cycles.
- R3: Every SCL high period lasts exactly T clock cycles, and `sda_oe` does not change during that period.
- R4: The eight bits go out MSB first. A 0 bit is sent as `sda_oe`=1 and a 1 bit as `sda_oe`=0. An address byte carries the 7-bit address in bits 7..1 and R/W in bit 0. When SCL falls after the eighth high period, `buf_full` clears and SDA is released.
- R5: The synchronized SDA level is sampled at the end of the ninth high period. A low level (ACK) gives `ack_stat`=0 and a high level (NACK) gives `ack_stat`=1.
- R6: When SCL falls after the ninth clock, `irq` sets. `scl_oe` then stays 1 and `sda_oe` stays 0 until the next accepted write.
- R7: A write made between acceptance and the end of the ninth clock is discarded, so the byte on the bus is unchanged, and it sets `wcol`.
- R8: `wcol` stays set until `clr_wcol` is pulsed. When a set and a clear happen in the same cycle, the set wins.
- R9: `irq` stays set until `clr_irq` is pulsed. When a set and a clear happen in the same cycle, the set wins.
- R10: After reset, `scl_oe`=1, `sda_oe`=0, and `buf_full`, `wcol`, `irq` and `ack_stat` are all 0.
- R11: `brg_wr` loads `brg_data` as the reload value. The new value takes effect at the start of the next SCL phase, and a reload of 0 behaves like a reload of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| brg_wr | input | 1 | Baud reload write strobe |
| brg_data | input | BRG_W | Baud reload value |
| clr_wcol | input | 1 | Clears the collision flag |
| clr_irq | input | 1 | Clears the completion flag |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | SDA pull-low enable |
| scl_oe | output | 1 | SCL pull-low enable |
| buf_full | output | 1 | Byte loaded and not yet fully shifted |
| wcol | output | 1 | Sticky write-collision flag |
| ack_stat | output | 1 | 0 = ACK received, 1 = NACK |
| irq | output | 1 | Sticky byte-complete flag |

## Verification
The assertions check four things on every cycle. SDA moves only inside a low SCL phase. A write is either accepted into `buf_full` or turned into a collision. The sticky flags hold until they are cleared. Completion parks the bus with SCL low and SDA free. Other behaviours can only be shown by the bench's scenarios: the bit order on the line, the exact phase lengths for each reload value, the captured ACK or NACK level, and the fact that a rejected byte never reaches the bus.

// File: rtl/i2c_txe_pkg.sv
package i2c_txe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = 4;
endpackage

// File: rtl/txe_sync.sv
module txe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/txe_baud.sv
module txe_baud #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff;

  // a reload of zero is promoted to one so SDA always has setup time
  assign eff = (reload == '0) ? W'(1) : reload;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= eff;
    else if (run && cnt != '0) cnt <= cnt - W'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/txe_shift.sv
module txe_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '0;
    else if (load)  sreg <= din;
    else if (shift) sreg <= {sreg[W-2:0], 1'b0};
  end

  assign msb = sreg[W-1];
endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx
  import i2c_txe_pkg::*;
#(
  parameter int BRG_W       = 8,
  parameter int RELOAD_INIT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             brg_wr,
  input  logic [BRG_W-1:0] brg_data,
  input  logic             clr_wcol,
  input  logic             clr_irq,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             buf_full,
  output logic             wcol,
  output logic             ack_stat,
  output logic             irq
);
  localparam logic [BITCNT_W-1:0] LAST_DATA = BITCNT_W'(BYTE_W - 1);
  localparam logic [BITCNT_W-1:0] ACK_SLOT  = BITCNT_W'(BYTE_W);

  phase_e              phase;
  logic [BITCNT_W-1:0] bit_cnt;
  logic                sda_pend;
  logic [BRG_W-1:0]    reload_q;
  logic                sda_sync;
  logic                expire;
  logic                msb;
  logic                busy;
  logic                accept;
  logic                rise_now;
  logic                fall_now;
  logic                ack_now;
  logic                brg_load;
  logic                sh_load;
  logic                sh_step;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    accept   = (phase == PH_IDLE) && wr_en;
    rise_now = (phase == PH_LOW)  && expire;
    fall_now = (phase == PH_HIGH) && expire && (bit_cnt != ACK_SLOT);
    ack_now  = (phase == PH_HIGH) && expire && (bit_cnt == ACK_SLOT);
    brg_load = accept || rise_now || fall_now;
    sh_load  = accept;
    sh_step  = fall_now;
  end

  txe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_in),
    .q   (sda_sync)
  );

  txe_baud #(.W(BRG_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (brg_load),
    .run    (busy),
    .reload (reload_q),
    .expire (expire)
  );

  txe_shift #(.W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .din   (wr_data),
    .shift (sh_step),
    .msb   (msb)
  );

  // reload register
  always_ff @(posedge clk) begin
    if (rst)         reload_q <= BRG_W'(RELOAD_INIT);
    else if (brg_wr) reload_q <= brg_data;
  end

  // phase sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
    end else begin
      if (accept) begin
        phase   <= PH_LOW;
        bit_cnt <= '0;
      end else if (rise_now) begin
        phase <= PH_HIGH;
      end else if (fall_now) begin
        phase   <= PH_LOW;
        bit_cnt <= bit_cnt + BITCNT_W'(1);
      end else if (ack_now) begin
        phase <= PH_IDLE;
      end
    end
  end

  // bus line drivers: SDA updates one cycle after SCL is pulled low
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe   <= 1'b1;
      sda_oe   <= 1'b0;
      sda_pend <= 1'b0;
    end else begin
      sda_pend <= accept || fall_now;
      if (sda_pend)
        sda_oe <= (bit_cnt == ACK_SLOT) ? 1'b0 : ~msb;
      if (rise_now)
        scl_oe <= 1'b0;
      else if (fall_now || ack_now)
        scl_oe <= 1'b1;
    end
  end

  // host status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      wcol     <= 1'b0;
      ack_stat <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (accept)
        buf_full <= 1'b1;
      else if (fall_now && bit_cnt == LAST_DATA)
        buf_full <= 1'b0;

      if (wr_en && busy) wcol <= 1'b1;
      else if (clr_wcol) wcol <= 1'b0;

      if (ack_now) ack_stat <= sda_sync;

      if (ack_now)      irq <= 1'b1;
      else if (clr_irq) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_txe_chk.sv
module i2c_txe_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic clr_wcol,
  input logic clr_irq,
  input logic busy,
  input logic scl_oe,
  input logic sda_oe,
  input logic buf_full,
  input logic wcol,
  input logic irq
);
  AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> (buf_full && busy)); // R1

  AST_SDA_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (scl_oe && $past(scl_oe))); // R2

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R3

  AST_DONE_PARKS_BUS: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (scl_oe && !sda_oe && !busy)); // R6

  AST_IDLE_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_en) |=> scl_oe); // R6

  AST_BUSY_WR_COLLIDES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> wcol); // R7

  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wcol && !clr_wcol) |=> wcol); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_irq) |=> irq); // R9
endmodule

bind i2c_byte_tx i2c_txe_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .clr_wcol (clr_wcol),
  .clr_irq  (clr_irq),
  .busy     (busy),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .buf_full (buf_full),
  .wcol     (wcol),
  .irq      (irq)
);

// File: tb/tb_i2c_byte_tx.sv
module tb_i2c_byte_tx;
  localparam int CLK_PERIOD = 10;
  localparam int BRG_W      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic brg_wr = 1'b0;
  logic [BRG_W-1:0] brg_data = '0;
  logic clr_wcol = 1'b0;
  logic clr_irq = 1'b0;
  logic sda_in;
  logic sda_oe, scl_oe, buf_full, wcol, ack_stat, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit want_ack = 1'b0;
  int exp_t = 5;
  int n_rel = 0;
  int n_fall = 0;
  int lo_len = 0;
  int hi_len = 0;
  logic [8:0] rx = '0;
  logic prev_scl = 1'b1;
  logic slave_pull;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign slave_pull = want_ack && (n_fall == 8);
  assign sda_in = !(sda_oe || slave_pull);

  i2c_byte_tx #(.BRG_W(BRG_W), .RELOAD_INIT(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .brg_wr(brg_wr), .brg_data(brg_data), .clr_wcol(clr_wcol),
    .clr_irq(clr_irq), .sda_in(sda_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .buf_full(buf_full), .wcol(wcol), .ack_stat(ack_stat), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int reload);
    return ((reload < 1) ? 1 : reload) + 1;
  endfunction

  // line monitor, samples on the falling clock edge
  always @(negedge clk) begin
    if (rst || clr_irq) begin
      n_rel = 0; n_fall = 0; lo_len = 0; hi_len = 0; rx = '0;
    end else if (prev_scl && !scl_oe) begin
      if (n_rel > 0) chk(lo_len == exp_t, "R2 R11 low period", lo_len, exp_t);
      if (n_rel < 8) chk(buf_full == 1'b1, "R4 buf_full during data", buf_full, 1);
      else           chk(buf_full == 1'b0, "R4 buf_full at ninth clock", buf_full, 0);
      rx = {rx[7:0], sda_in};
      n_rel++;
      hi_len = 1;
    end else if (!prev_scl && scl_oe) begin
      chk(hi_len == exp_t, "R3 R11 high period", hi_len, exp_t);
      n_fall++;
      lo_len = 1;
    end else if (scl_oe) begin
      lo_len++;
    end else begin
      hi_len++;
    end
    prev_scl = scl_oe;
  end

  task automatic drive_reload(input int r);
    @(posedge clk); #1;
    brg_wr = 1'b1; brg_data = BRG_W'(r);
    @(posedge clk); #1;
    brg_wr = 1'b0;
    exp_t = period_of(r);
  endtask

  task automatic pulse_clr_irq();
    @(posedge clk); #1; clr_irq = 1'b1;
    @(posedge clk); #1; clr_irq = 1'b0;
  endtask

  task automatic start_byte(input logic [7:0] d, input bit ack);
    pulse_clr_irq();
    want_ack = ack;
    @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    chk(buf_full == 1'b1, "R1 buf_full after write", buf_full, 1);
  endtask

  task automatic finish_byte(input logic [7:0] d, input bit ack);
    int guard;
    guard = 0;
    while (irq !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(irq == 1'b1, "R6 irq at completion", irq, 1);
    chk(rx[8:1] == d, "R4 bits on SDA", rx[8:1], d);
    chk(rx[0] == !ack, "R5 ninth-clock line", rx[0], !ack);
    chk(ack_stat == !ack, "R5 ack_stat", ack_stat, !ack);
    chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R6 parked lines", {scl_oe, sda_oe}, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(scl_oe == 1'b1, "R10 scl_oe", scl_oe, 1);
    chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    chk({buf_full, wcol, irq, ack_stat} == 4'b0, "R10 flags", {buf_full, wcol, irq, ack_stat}, 0);

    // directed: address byte with ACK at the default reload
    exp_t = period_of(4);
    start_byte(8'hA4, 1'b1);
    finish_byte(8'hA4, 1'b1);

    // R6: bus stays parked with no new write; R9: irq sticky
    repeat (30) @(negedge clk);
    chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R6 held after idle", {scl_oe, sda_oe}, 2);
    chk(irq == 1'b1, "R9 irq sticky", irq, 1);
    pulse_clr_irq();
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);

    // R11: reload of zero behaves as one; NACK case
    drive_reload(0);
    start_byte(8'h3C, 1'b0);
    finish_byte(8'h3C, 1'b0);

    // R7: write during shift is discarded and sets wcol
    drive_reload(3);
    start_byte(8'h96, 1'b1);
    repeat (12) @(posedge clk);
    #1 wr_en = 1'b1; wr_data = 8'h0F;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    chk(wcol == 1'b1, "R7 wcol on busy write", wcol, 1);
    finish_byte(8'h96, 1'b1);

    // R8: wcol sticky until cleared
    repeat (5) @(negedge clk);
    chk(wcol == 1'b1, "R8 wcol sticky", wcol, 1);
    @(posedge clk); #1 clr_wcol = 1'b1;
    @(posedge clk); #1 clr_wcol = 1'b0;
    @(negedge clk);
    chk(wcol == 1'b0, "R8 wcol cleared", wcol, 0);

    // constrained random bytes, reloads and acknowledge levels
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      bit a;
      d = 8'($urandom);
      a = 1'($urandom);
      drive_reload(int'($urandom % 5));
      start_byte(d, a);
      finish_byte(d, a);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule